// File: doc/BRIEF.md
# Serial Link Transmit Gate and Pacer

This block sits between a local packet source and the transmit side of a serial link. Packets arrive as a stream of 32-bit words with valid, ready and last. A 32-bit control word decides whether each packet may leave. The block can pass packets unchanged, replace every payload word with an incrementing test pattern, or hold the stream closed. It can also hold off the next packet for a programmable idle time, or while a flow-control stop is in force.

Every decision is taken at a packet boundary, so a packet that has begun is never cut short. The same control word sets the outgoing stop request that goes to the link partner. It also produces a single-cycle reboot command strobe for that partner. The data path is a gated pass-through. Valid goes forward and ready comes back within the same cycle, and a small amount of state tracks packet position, pacing and latched per-packet settings.

Top module: `link_tx_pacer`

## Requirements
- R1: After reset, with the control word at zero, m_valid, s_ready, stop_out and reboot_pulse are all low.
- R2: When control bit 1 (stream enable) is clear at a packet boundary, s_ready and m_valid stay low and no word is forwarded.
- R3: When enabled and not held, each input word is forwarded in the same cycle: m_data equals s_data, m_last equals s_last, s_ready equals m_ready.
- R4: With control bit 8 set, the k-th word of a packet (k counted from 1) leaves as k*0x11111111 modulo 2^32. The sequence restarts for each packet and wraps past 0xFFFFFFFF, and m_last still follows s_last.
- R5: With control bit 10 set, N = (bits 31..24) * 4096, which places the 8-bit value in the top bits of a 20-bit down-counter. After the last word of a packet is accepted, s_ready stays low for N cycles, so the next packet's first word is accepted N+1 cycles after that last word. With bit 10 clear, packets may follow back to back (1 cycle).
- R6: At a packet boundary the stream is held when control bit 5 is set, or when control bit 4 is set and remote_stop_in is high. With bit 4 clear, remote_stop_in has no effect.
- R7: If the stream enable is cleared or a stop is applied in the middle of a packet, the rest of that packet is still forwarded. The hold applies from the next boundary on.
- R8: stop_out equals bit 7 OR (bit 6 AND local_stop_req), registered with one cycle of latency.
- R9: A rising edge on control bit 11 gives reboot_pulse high for exactly one cycle, one cycle later. Holding the bit high gives no further pulses.
- R10: Bits 8, 10 and 31..24 are sampled when a packet's first word is accepted. A change made during a packet takes effect from the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Control word |
| remote_stop_in | input | 1 | Stop request received from the link partner |
| local_stop_req | input | 1 | Local wish to ask the partner to stop |
| s_valid | input | 1 | Input word valid |
| s_data | input | 32 | Input word |
| s_last | input | 1 | Input word ends the packet |
| s_ready | output | 1 | Input word accepted this cycle when valid |
| m_valid | output | 1 | Output word valid |
| m_data | output | 32 | Output word (payload or test pattern) |
| m_last | output | 1 | Output word ends the packet |
| m_ready | input | 1 | Link accepts the output word |
| stop_out | output | 1 | Stop request sent to the link partner |
| reboot_pulse | output | 1 | One-cycle reboot command toward the partner |

## Verification
The hardest cases to reach are control changes that land inside a packet. Only the boundary sampling separates the correct behaviour from an immediate one there. The stimulus therefore changes the control word at a chosen word index within a packet that is already open. In one case it clears the enable and forces a stop; in others it sets the pattern bit or the gap settings. It then measures the next packet's pattern and its exact start cycle. Gap lengths are swept over several 8-bit values, each with pacing on and off, and the measured cycle distance is compared with N+1.

// File: rtl/link_pacer_pkg.sv
package link_pacer_pkg;
  localparam int CB_STREAM_EN  = 1;
  localparam int CB_HONOR_STOP = 4;
  localparam int CB_FORCE_STOP = 5;
  localparam int CB_ALLOW_REQ  = 6;
  localparam int CB_FORCE_REQ  = 7;
  localparam int CB_PATTERN    = 8;
  localparam int CB_GAP_EN     = 10;
  localparam int CB_REBOOT     = 11;
  localparam int CB_GAP_LSB    = 24;

  typedef enum logic {
    ST_BOUNDARY = 1'b0,
    ST_INPKT    = 1'b1
  } pkt_state_e;
endpackage

// File: rtl/pacer_gap_timer.sv
module pacer_gap_timer #(
  parameter int CNT_W = 20,
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  output logic             idle
);
  localparam int SHIFT = CNT_W - VAL_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= {load_val, {SHIFT{1'b0}}};
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign idle = (cnt_q == '0);

  AST_GAP_STEPS: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q))); // R5
endmodule

// File: rtl/pacer_pattern_gen.sv
module pacer_pattern_gen #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_boundary,
  input  logic              advance,
  output logic [DATA_W-1:0] word
);
  localparam int NIB = DATA_W / 4;
  localparam logic [DATA_W-1:0] STEP = {NIB{4'h1}};

  logic [DATA_W-1:0] next_q;

  assign word = at_boundary ? STEP : next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_q <= STEP;
    end else if (advance) begin
      next_q <= word + STEP;
    end
  end
endmodule

// File: rtl/pacer_ctrl_decode.sv
module pacer_ctrl_decode (
  input  logic clk,
  input  logic rst,
  input  logic reboot_bit,
  input  logic allow_req,
  input  logic force_req,
  input  logic local_stop,
  output logic reboot_pulse,
  output logic stop_out
);
  logic reboot_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reboot_prev_q <= 1'b0;
      reboot_pulse  <= 1'b0;
      stop_out      <= 1'b0;
    end else begin
      reboot_prev_q <= reboot_bit;
      reboot_pulse  <= reboot_bit && !reboot_prev_q;
      stop_out      <= force_req || (allow_req && local_stop);
    end
  end

  AST_REBOOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reboot_pulse |=> !reboot_pulse); // R9
  AST_REBOOT_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(reboot_pulse) |-> $past(reboot_bit)); // R9
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!force_req && !allow_req) |=> !stop_out); // R8
endmodule

// File: rtl/link_tx_pacer.sv
module link_tx_pacer
  import link_pacer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GAP_CNT_W = 20,
  parameter int GAP_VAL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       ctrl_word,
  input  logic              remote_stop_in,
  input  logic              local_stop_req,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  input  logic              m_ready,
  output logic              stop_out,
  output logic              reboot_pulse
);
  localparam logic [DATA_W-1:0] STEP = {(DATA_W/4){4'h1}};

  pkt_state_e       state_q;
  logic             lat_pat_q;
  logic             lat_gap_en_q;
  logic [GAP_VAL_W-1:0] lat_gap_val_q;

  logic             in_pkt;
  logic             stop_hold;
  logic             gap_idle;
  logic             gate_open;
  logic             accept;
  logic             pat_sel;
  logic             gap_en_eff;
  logic [GAP_VAL_W-1:0] gap_val_eff;
  logic [DATA_W-1:0] pat_word;

  assign in_pkt    = (state_q == ST_INPKT);
  assign stop_hold = ctrl_word[CB_FORCE_STOP] ||
                     (ctrl_word[CB_HONOR_STOP] && remote_stop_in);
  assign gate_open = in_pkt ||
                     (ctrl_word[CB_STREAM_EN] && !stop_hold && gap_idle);

  assign s_ready = m_ready && gate_open;
  assign m_valid = s_valid && gate_open;
  assign accept  = s_valid && m_ready && gate_open;

  assign pat_sel     = in_pkt ? lat_pat_q    : ctrl_word[CB_PATTERN];
  assign gap_en_eff  = in_pkt ? lat_gap_en_q : ctrl_word[CB_GAP_EN];
  assign gap_val_eff = in_pkt ? lat_gap_val_q
                              : ctrl_word[CB_GAP_LSB +: GAP_VAL_W];

  assign m_data = pat_sel ? pat_word : s_data;
  assign m_last = s_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_BOUNDARY;
      lat_pat_q     <= 1'b0;
      lat_gap_en_q  <= 1'b0;
      lat_gap_val_q <= '0;
    end else if (accept) begin
      state_q <= s_last ? ST_BOUNDARY : ST_INPKT;
      if (!in_pkt) begin
        lat_pat_q     <= ctrl_word[CB_PATTERN];
        lat_gap_en_q  <= ctrl_word[CB_GAP_EN];
        lat_gap_val_q <= ctrl_word[CB_GAP_LSB +: GAP_VAL_W];
      end
    end
  end

  pacer_gap_timer #(
    .CNT_W (GAP_CNT_W),
    .VAL_W (GAP_VAL_W)
  ) i_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (accept && s_last && gap_en_eff),
    .load_val (gap_val_eff),
    .idle     (gap_idle)
  );

  pacer_pattern_gen #(
    .DATA_W (DATA_W)
  ) i_pat (
    .clk         (clk),
    .rst         (rst),
    .at_boundary (!in_pkt),
    .advance     (accept),
    .word        (pat_word)
  );

  pacer_ctrl_decode i_dec (
    .clk          (clk),
    .rst          (rst),
    .reboot_bit   (ctrl_word[CB_REBOOT]),
    .allow_req    (ctrl_word[CB_ALLOW_REQ]),
    .force_req    (ctrl_word[CB_FORCE_REQ]),
    .local_stop   (local_stop_req),
    .reboot_pulse (reboot_pulse),
    .stop_out     (stop_out)
  );

  AST_CLOSED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!in_pkt && !ctrl_word[CB_STREAM_EN]) |-> (!m_valid && !s_ready)); // R2
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !pat_sel) |-> (m_data == s_data && m_last == s_last)); // R3
  AST_PATTERN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!in_pkt && ctrl_word[CB_PATTERN] && m_valid) |-> (m_data == STEP)); // R4
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_pkt && !gap_idle) |-> !s_ready); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_pkt && ctrl_word[CB_FORCE_STOP]) |-> !m_valid); // R6
  AST_PKT_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
    (in_pkt && m_ready) |-> s_ready); // R7
endmodule

// File: tb/test_link_tx_pacer.sv
module test_link_tx_pacer;
  localparam logic [31:0] EN   = 32'h0000_0002;
  localparam logic [31:0] HON  = 32'h0000_0010;
  localparam logic [31:0] FST  = 32'h0000_0020;
  localparam logic [31:0] ARQ  = 32'h0000_0040;
  localparam logic [31:0] FRQ  = 32'h0000_0080;
  localparam logic [31:0] PAT  = 32'h0000_0100;
  localparam logic [31:0] GAP  = 32'h0000_0400;
  localparam logic [31:0] RBT  = 32'h0000_0800;
  localparam logic [31:0] STEP = 32'h1111_1111;

  logic clk = 1'b0;
  logic rst;
  logic [31:0] ctrl_word;
  logic remote_stop_in, local_stop_req;
  logic s_valid, s_last, s_ready, m_valid, m_last, m_ready;
  logic [31:0] s_data, m_data;
  logic stop_out, reboot_pulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rb_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && reboot_pulse) rb_cnt <= rb_cnt + 1;

  link_tx_pacer i_link_tx_pacer (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
    .remote_stop_in(remote_stop_in), .local_stop_req(local_stop_req),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
    .stop_out(stop_out), .reboot_pulse(reboot_pulse)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input logic [31:0] base, input bit exp_pat,
                          input int chg_at, input logic [31:0] chg_ctrl,
                          input string req, output int first_cyc, output int last_cyc);
    logic [31:0] expw;
    int w;
    first_cyc = -1;
    last_cyc  = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == chg_at) ctrl_word = chg_ctrl;
      s_valid = 1'b1;
      s_data  = base + 32'(i);
      s_last  = (i == len - 1);
      #1;
      w = 0;
      while (!s_ready && w < 40000) begin
        @(negedge clk);
        #1;
        w++;
      end
      if (!s_ready) begin
        check(req, "ready never rose", 32'(s_ready), 32'd1);
        return;
      end
      expw = exp_pat ? (32'(i + 1) * STEP) : (base + 32'(i));
      check(req, "m_data", m_data, expw);
      check(req, "m_valid/m_last", {30'd0, m_valid, m_last},
            {30'd0, 1'b1, (i == len - 1)});
      if (i == 0) first_cyc = cyc;
      if (i == len - 1) last_cyc = cyc;
    end
  endtask

  task automatic hold_check(input int n, input string req);
    bit ok;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = 32'hDEAD_0000 + 32'(i);
      s_last  = 1'b1;
      #1;
      if (s_ready || m_valid) ok = 0;
    end
    check(req, "held (no forward)", 32'(ok), 32'd1);
  endtask

  task automatic go_idle();
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int f, l, f2, l2, expd;
    rst = 1'b1;
    ctrl_word = '0;
    remote_stop_in = 0; local_stop_req = 0;
    s_valid = 0; s_data = '0; s_last = 0; m_ready = 1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "outputs after reset",
          {28'd0, m_valid, s_ready, stop_out, reboot_pulse}, 32'd0);

    // R2 stream disabled
    hold_check(20, "R2");

    // R3 pass-through, several lengths, m_ready stall handled by gate
    ctrl_word = EN;
    for (int n = 1; n <= 6; n++) begin
      send_pkt(n, 32'hA000_0000 + 32'(n * 16), 0, -1, '0, "R3", f, l);
    end
    go_idle();
    @(negedge clk);
    m_ready = 0; s_valid = 1; s_last = 1; #1;
    check("R3", "ready follows m_ready", 32'(s_ready), 32'd0);
    m_ready = 1;
    go_idle();

    // R4 pattern, lengths crossing the wrap (word 16)
    ctrl_word = EN | PAT;
    for (int n = 1; n <= 20; n += 3) begin
      send_pkt(n, 32'h5000_0000, 1, -1, '0, "R4", f, l);
    end
    go_idle();

    // R5 gap sweep
    for (int v = 0; v < 3; v++) begin
      for (int e = 0; e < 2; e++) begin
        ctrl_word = EN | (e ? GAP : 32'd0) | (32'(v) << 24);
        send_pkt(2, 32'hB000_0000, 0, -1, '0, "R5", f, l);
        send_pkt(1, 32'hB100_0000, 0, -1, '0, "R5", f2, l2);
        expd = e ? (v * 4096 + 1) : 1;
        check("R5", "packet distance", 32'(f2 - l), 32'(expd));
      end
    end
    ctrl_word = EN;
    go_idle();
    repeat (3 * 4096) @(negedge clk);

    // R6 stop handling
    ctrl_word = EN | HON; remote_stop_in = 1;
    hold_check(20, "R6");
    go_idle();
    ctrl_word = EN;
    send_pkt(3, 32'hC000_0000, 0, -1, '0, "R6", f, l);
    go_idle();
    remote_stop_in = 0; ctrl_word = EN | FST;
    hold_check(20, "R6");
    go_idle();
    ctrl_word = EN | HON;
    send_pkt(2, 32'hC100_0000, 0, -1, '0, "R6", f, l);
    go_idle();

    // R7 stop and disable inside a packet
    ctrl_word = EN;
    send_pkt(5, 32'hD000_0000, 0, 2, FST, "R7", f, l);
    hold_check(20, "R7");
    go_idle();
    ctrl_word = EN;
    send_pkt(4, 32'hD100_0000, 0, 1, 32'd0, "R7", f, l);
    hold_check(10, "R7");
    go_idle();

    // R10 pattern and gap changes mid-packet apply next packet
    ctrl_word = EN;
    send_pkt(4, 32'hE000_0000, 0, 1, EN | PAT, "R10", f, l);
    send_pkt(3, 32'hE100_0000, 1, -1, '0, "R10", f, l);
    go_idle();
    ctrl_word = EN;
    send_pkt(3, 32'hE200_0000, 0, 1, EN | GAP | (32'd1 << 24), "R10", f, l);
    send_pkt(2, 32'hE300_0000, 0, -1, '0, "R10", f2, l2);
    check("R10", "gap not applied to open packet", 32'(f2 - l), 32'd1);
    send_pkt(1, 32'hE400_0000, 0, -1, '0, "R10", f, l);
    check("R10", "gap applied next packet", 32'(f - l2), 32'd4097);
    go_idle();
    ctrl_word = EN;

    // R8 outgoing stop sweep
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ctrl_word = EN | (k[0] ? ARQ : 32'd0) | (k[1] ? FRQ : 32'd0);
      local_stop_req = k[2];
      @(negedge clk); #1;
      check("R8", "stop_out", 32'(stop_out), 32'(k[1] | (k[0] & k[2])));
    end
    local_stop_req = 0;

    // R9 reboot strobe
    @(negedge clk);
    ctrl_word = EN;
    rb_cnt = 0;
    @(negedge clk);
    ctrl_word = EN | RBT;
    @(negedge clk); #1;
    check("R9", "pulse one cycle after edge", 32'(reboot_pulse), 32'd1);
    @(negedge clk); #1;
    check("R9", "pulse drops", 32'(reboot_pulse), 32'd0);
    repeat (10) @(negedge clk);
    ctrl_word = EN;
    repeat (3) @(negedge clk);
    ctrl_word = EN | RBT;
    repeat (10) @(negedge clk);
    #1;
    check("R9", "pulse count", 32'(rb_cnt), 32'd2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule